// File: doc/BRIEF.md
# Local-Bus Hold Arbiter

This block hands the local bus to an external master and takes it back. The external master raises a level-sensitive request that is synchronous to the clock. The arbiter lets the bus cycle in progress finish and then raises the acknowledge. While the acknowledge is high, the arbiter raises a float enable. The pad drivers use that enable to release address/data, status, strobes, byte enables, data enable and the direction line. During the same interval every active-low chip select is forced high. When the external master drops its request, the arbiter drops the acknowledge and the bus is driven again.

An internal refresh request outranks the external master. If the two requests arrive together, refresh is granted first and the hold is considered only after refresh completes. If refresh asks for the bus during a hold, the acknowledge is withdrawn at once while the external request is still high. The arbiter then waits in a reclaim state until the external master lets go of its request. Only after that is refresh granted.

The machine has five states. ST_IDLE goes to ST_REFRESH on a refresh request and otherwise to ST_WAIT_END on a hold request. ST_WAIT_END goes to ST_REFRESH on a refresh request, back to ST_IDLE if the hold request drops, and to ST_HOLD once the bus cycle is no longer busy. ST_HOLD goes to ST_RECLAIM on a refresh request and otherwise to ST_IDLE when the hold request drops. ST_RECLAIM goes to ST_IDLE when the hold request drops. ST_REFRESH goes to ST_IDLE when the refresh request drops.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While reset is asserted (asynchronous, active low), hold_ack, bus_float and refresh_gnt are low, dir_float is high, and the chip selects pass through unchanged.
- R2: hold_ack rises only on the clock edge after a cycle in which hold_req was high, cycle_busy was low and refresh_req was low. From idle with the bus not busy, it rises on the second edge after the request.
- R3: While hold_ack is high, every bit of cs_n_out is 1. While it is low, cs_n_out equals cs_n_in.
- R4: bus_float and dir_float are high in exactly the cycles hold_ack is high, outside reset.
- R5: Once hold_ack is high, it falls on the edge after a cycle in which hold_req is low. cycle_busy has no effect on it.
- R6: A refresh_req seen while hold_ack is high drops hold_ack on the next edge, even though hold_req is still high.
- R7: After such a withdrawal, hold_ack stays low and refresh_gnt stays low until hold_req has been seen low. Refresh is granted on the second edge after that.
- R8: When refresh_req and hold_req are both pending in idle, refresh_gnt rises first and hold_ack never rises while refresh_gnt is high.
- R9: refresh_gnt stays high while refresh_req stays high, and falls on the edge after refresh_req drops.
- R10: If hold_req drops while the arbiter is waiting for the bus cycle to end, no acknowledge is given and the arbiter returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | External bus master request, level-sensitive |
| cycle_busy | input | 1 | High while the bus cycle engine has a cycle in progress |
| refresh_req | input | 1 | Internal refresh request, held until serviced |
| cs_n_in | input | NUM_CS | Active-low chip selects from the address decoder |
| hold_ack | output | 1 | Bus handed to the external master |
| bus_float | output | 1 | Float enable for address, data, status, strobe and enable pads |
| dir_float | output | 1 | Float enable for the transceiver direction pad |
| refresh_gnt | output | 1 | Refresh cycle may use the bus |
| cs_n_out | output | NUM_CS | Chip selects to the pads, forced high during hold |

## Verification
The hardest situation to reach is the reclaim path. The external master must hold its request through an entire refresh-forced withdrawal while refresh stays pending. The stimulus table first brings the arbiter into hold and then raises refresh_req for two cycles with hold_req still high. In those cycles it checks that neither acknowledge nor refresh grant is given. It then drops hold_req with refresh still pending, to confirm that the grant follows only afterwards.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_END = 3'd1,
        ST_HOLD     = 3'd2,
        ST_RECLAIM  = 3'd3,
        ST_REFRESH  = 3'd4
    } hold_state_t;

endpackage

// File: rtl/bus_hold_next.sv
module bus_hold_next
    import bus_hold_pkg::*;
(
    input  hold_state_t cur_st,
    input  logic        hold_req,
    input  logic        cycle_busy,
    input  logic        refresh_req,
    output hold_state_t nxt_st
);

    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            ST_IDLE: begin
                if (refresh_req)   nxt_st = ST_REFRESH;
                else if (hold_req) nxt_st = ST_WAIT_END;
            end
            ST_WAIT_END: begin
                if (refresh_req)      nxt_st = ST_REFRESH;
                else if (!hold_req)   nxt_st = ST_IDLE;
                else if (!cycle_busy) nxt_st = ST_HOLD;
            end
            ST_HOLD: begin
                if (refresh_req)    nxt_st = ST_RECLAIM;
                else if (!hold_req) nxt_st = ST_IDLE;
            end
            ST_RECLAIM: begin
                if (!hold_req) nxt_st = ST_IDLE;
            end
            ST_REFRESH: begin
                if (!refresh_req) nxt_st = ST_IDLE;
            end
            default: nxt_st = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/bus_hold_outputs.sv
module bus_hold_outputs
    import bus_hold_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input  hold_state_t       cur_st,
    input  logic              rst_n,
    input  logic [NUM_CS-1:0] cs_n_in,
    output logic              hold_ack,
    output logic              bus_float,
    output logic              dir_float,
    output logic              refresh_gnt,
    output logic [NUM_CS-1:0] cs_n_out
);

    logic in_hold;

    always_comb begin
        in_hold     = 1'b0;
        refresh_gnt = 1'b0;
        unique case (cur_st)
            ST_IDLE:     ;
            ST_WAIT_END: ;
            ST_HOLD:     in_hold = 1'b1;
            ST_RECLAIM:  ;
            ST_REFRESH:  refresh_gnt = 1'b1;
            default:     ;
        endcase
        hold_ack  = in_hold;
        bus_float = in_hold;
        dir_float = in_hold | ~rst_n;
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs_gate
        assign cs_n_out[i] = cs_n_in[i] | in_hold;
    end

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
    import bus_hold_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_req,
    input  logic              cycle_busy,
    input  logic              refresh_req,
    input  logic [NUM_CS-1:0] cs_n_in,
    output logic              hold_ack,
    output logic              bus_float,
    output logic              dir_float,
    output logic              refresh_gnt,
    output logic [NUM_CS-1:0] cs_n_out
);

    hold_state_t state_q;
    hold_state_t state_d;

    bus_hold_next u_next (
        .cur_st      (state_q),
        .hold_req    (hold_req),
        .cycle_busy  (cycle_busy),
        .refresh_req (refresh_req),
        .nxt_st      (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    bus_hold_outputs #(.NUM_CS(NUM_CS)) u_out (
        .cur_st      (state_q),
        .rst_n       (rst_n),
        .cs_n_in     (cs_n_in),
        .hold_ack    (hold_ack),
        .bus_float   (bus_float),
        .dir_float   (dir_float),
        .refresh_gnt (refresh_gnt),
        .cs_n_out    (cs_n_out)
    );

endmodule

// File: rtl/bus_hold_checker.sv
module bus_hold_checker #(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_req,
    input logic              cycle_busy,
    input logic              refresh_req,
    input logic              hold_ack,
    input logic              bus_float,
    input logic              dir_float,
    input logic              refresh_gnt,
    input logic [NUM_CS-1:0] cs_n_out
);

    AST_ACK_NEEDS_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(hold_req && !cycle_busy && !refresh_req)); // R2

    AST_CS_HIGH_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (&cs_n_out)); // R3

    AST_FLOAT_MATCHES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_float == hold_ack) && (dir_float == hold_ack)); // R4

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && !hold_req) |=> !hold_ack); // R5

    AST_REFRESH_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && refresh_req) |=> !hold_ack); // R6

    AST_NO_GNT_AND_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_ack && refresh_gnt)); // R8

    AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_gnt && refresh_req) |=> refresh_gnt); // R9

    AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_gnt && !refresh_req) |=> !refresh_gnt); // R9

endmodule

bind bus_hold_arbiter bus_hold_checker #(.NUM_CS(NUM_CS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_req    (hold_req),
    .cycle_busy  (cycle_busy),
    .refresh_req (refresh_req),
    .hold_ack    (hold_ack),
    .bus_float   (bus_float),
    .dir_float   (dir_float),
    .refresh_gnt (refresh_gnt),
    .cs_n_out    (cs_n_out)
);

// File: tb/bus_hold_arbiter_tb_top.sv
module bus_hold_arbiter_tb_top;

    localparam int NUM_CS = 8;
    localparam int NVEC   = 20;
    localparam logic [NUM_CS-1:0] CS_PAT = 8'h5A;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hold_req = 1'b0;
    logic              cycle_busy = 1'b0;
    logic              refresh_req = 1'b0;
    logic [NUM_CS-1:0] cs_n_in = CS_PAT;
    logic              hold_ack, bus_float, dir_float, refresh_gnt;
    logic [NUM_CS-1:0] cs_n_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bus_hold_arbiter #(.NUM_CS(NUM_CS)) dut_i (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cycle_busy(cycle_busy),
        .refresh_req(refresh_req), .cs_n_in(cs_n_in), .hold_ack(hold_ack),
        .bus_float(bus_float), .dir_float(dir_float), .refresh_gnt(refresh_gnt),
        .cs_n_out(cs_n_out)
    );

    // vector: {hold_req, cycle_busy, refresh_req, exp_ack, exp_gnt}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b110_00, // R2 wait for busy cycle
        5'b110_00, // R2 still busy
        5'b100_10, // R2 ack after cycle ends
        5'b110_10, // R5 busy ignored in hold
        5'b000_00, // R5 release
        5'b101_01, // R8 refresh first
        5'b101_01, // R9 grant held
        5'b100_00, // R9 grant falls
        5'b100_00, // R8 hold taken after refresh
        5'b100_10, // R8 ack
        5'b101_00, // R6 withdraw
        5'b101_00, // R7 reclaim, no grant
        5'b001_00, // R7 hold drops
        5'b001_01, // R7 grant
        5'b000_00, // R9 grant falls
        5'b110_00, // R10 waiting
        5'b010_00, // R10 withdrawn
        5'b000_00, // R10 idle
        5'b100_00, // R2 from idle
        5'b100_10  // R2 second edge
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req, input logic ea, input logic eg);
        chk(req, {31'd0, hold_ack}, {31'd0, ea});
        chk(req, {31'd0, refresh_gnt}, {31'd0, eg});
        chk("R4", {31'd0, bus_float}, {31'd0, ea});
        chk("R4", {31'd0, dir_float}, {31'd0, ea});
        chk("R3", {24'd0, cs_n_out}, {24'd0, (ea ? {NUM_CS{1'b1}} : cs_n_in)});
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        #5;
        chk("R1", {31'd0, hold_ack}, 32'd0);
        chk("R1", {31'd0, refresh_gnt}, 32'd0);
        chk("R1", {31'd0, bus_float}, 32'd0);
        chk("R1", {31'd0, dir_float}, 32'd1);
        chk("R1", {24'd0, cs_n_out}, {24'd0, CS_PAT});
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        for (int i = 0; i < NVEC; i++) begin
            hold_req    = VEC[i][4];
            cycle_busy  = VEC[i][3];
            refresh_req = VEC[i][2];
            cs_n_in     = (i % 2 == 0) ? CS_PAT : ~CS_PAT;
            @(posedge clk); #1;
            check_outputs($sformatf("R2/R10 vec%0d", i), VEC[i][1], VEC[i][0]);
        end

        // R1 reset during hold: outputs drop at once, dir floats
        hold_req = 1'b1; cycle_busy = 1'b0; refresh_req = 1'b0;
        @(posedge clk); #1;
        chk("R1", {31'd0, hold_ack}, 32'd1);
        rst_n = 1'b0;
        #1;
        chk("R1", {31'd0, hold_ack}, 32'd0);
        chk("R1", {31'd0, bus_float}, 32'd0);
        chk("R1", {31'd0, dir_float}, 32'd1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        hold_req = 1'b0;
        @(posedge clk); #1;
        chk("R1", {31'd0, hold_ack}, 32'd0);

        // R5 long hold: ack stays while request stays, busy toggling
        hold_req = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        for (int k = 0; k < 6; k++) begin
            cycle_busy = k[0];
            @(posedge clk); #1;
            chk("R5", {31'd0, hold_ack}, 32'd1);
        end
        hold_req = 1'b0;
        @(posedge clk); #1;
        chk("R5", {31'd0, hold_ack}, 32'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule